// File: doc/BRIEF.md
# Dual-Mode Overcurrent Protection Controller

This block is the digital half of a two-level current limit for a fixed-frequency PWM stage. Two current-sense comparator flags arrive from the analog side, one for a moderate trip level and one for a severe trip level. The flags are synchronised into the clock domain before use. A moderate trip cuts short only the conduction cycle in progress. The following oscillator cycle starts as usual.

A severe trip puts the block into skip mode. The drive output is forced off and the soft-start capacitor is told to discharge. A counter, cleared on entry, times a programmable off period. When the period ends, the block gives a one-clock skip-done pulse. Restart then waits until the supply monitor reports that the upper start threshold has been reached. The whole off time is therefore the timed period plus that wait. When the block leaves skip mode it emits a one-clock soft-start restart pulse.

The output latch is set by the oscillator cycle start while the modulator requests conduction. Any clear condition wins over a set in the same cycle.

Top module: `ocp_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `gate_out`, `cyc_term`, `skip_off`, `ss_discharge`, `skip_done` and `ss_restart` are all 0.
- R2: When `lo_trip_raw` goes high, `cyc_term` goes high after the second rising clock edge (two synchroniser stages) and `gate_out` falls at the third. Once the flag has cleared, the next `cyc_start` sets `gate_out` again.
- R3: The output latch is reset-dominant. A `cyc_start` that arrives while `cyc_term` is high leaves `gate_out` at 0.
- R4: When `hi_trip_raw` goes high, `skip_off` and `ss_discharge` are 1 after the third rising edge, and `gate_out` is 0 throughout skip mode.
- R5: With `skip_len` = L, `skip_done` pulses high for exactly one clock, L clocks after `skip_off` rises. This is L+2 edges after the end of a one-clock `hi_trip_raw` pulse.
- R6: A severe trip during an active skip period restarts the timer from zero. `skip_done` then comes L+2 edges after the later trip pulse.
- R7: After `skip_done`, `skip_off` stays high while `supply_ok` is 0, and `ss_discharge` is 0 in this wait. One edge after `supply_ok` is 1, `skip_off` clears and `ss_restart` is high for one clock.
- R8: A `skip_len` of 0 behaves as a skip period of one clock.
- R9: `gate_out` rises one edge after a `cyc_start` with `pwm_on` high, and falls one edge after `pwm_on` drops.
- R10: During skip mode, `cyc_start` with `pwm_on` high has no effect: `gate_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_trip_raw | input | 1 | Moderate-level comparator flag, asynchronous |
| hi_trip_raw | input | 1 | Severe-level comparator flag, asynchronous |
| cyc_start | input | 1 | Oscillator cycle-start pulse |
| pwm_on | input | 1 | Modulator conduction request |
| supply_ok | input | 1 | Supply has reached the upper start threshold |
| skip_len | input | SKIP_W | Skip period in clocks (0 acts as 1) |
| gate_out | output | 1 | Registered drive output |
| cyc_term | output | 1 | Per-cycle terminate, combinational from the synchronised moderate flag |
| skip_off | output | 1 | Output disable while skipping or waiting for supply |
| ss_discharge | output | 1 | Soft-start discharge request during the timed period |
| skip_done | output | 1 | One-clock pulse at the end of the timed period |
| ss_restart | output | 1 | One-clock pulse when soft start may begin |

## Verification
The assertions assume that the comparator flags are level signals seen for at least one clock. They also assume that `skip_len` stays constant while a skip period runs, and that `cyc_start` is a single-clock pulse. The bench drives every input one time unit after a rising edge and holds each trip flag for whole clocks. It changes `skip_len` only while the block is running normally, so the timer never sees a period change mid-count. It does not raise `supply_ok` during the wait until the hold behaviour has been observed.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SKIP = 2'd1,
    ST_HOLD = 2'd2
  } skip_state_t;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOP = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[TOP-1:0], d[b]};
    end
    assign q[b] = chain[TOP];
  end
endmodule

// File: rtl/ocp_skip_timer.sv
module ocp_skip_timer
  import ocp_pkg::*;
#(
  parameter int SKIP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_s,
  input  logic              supply_ok,
  input  logic [SKIP_W-1:0] skip_len,
  output logic              skip_off,
  output logic              ss_discharge,
  output logic              skip_done,
  output logic              ss_restart
);
  skip_state_t       state;
  logic [SKIP_W-1:0] cnt;
  logic [SKIP_W-1:0] term;

  // A zero period is clamped to a single clock
  assign term = (skip_len == '0) ? '0 : skip_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      cnt        <= '0;
      skip_done  <= 1'b0;
      ss_restart <= 1'b0;
    end else begin
      skip_done  <= 1'b0;
      ss_restart <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (hi_s) begin
            state <= ST_SKIP;
            cnt   <= '0;
          end
        end
        ST_SKIP: begin
          if (hi_s) begin
            cnt <= '0;
          end else if (cnt == term) begin
            state     <= ST_HOLD;
            skip_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (hi_s) begin
            state <= ST_SKIP;
            cnt   <= '0;
          end else if (supply_ok) begin
            state      <= ST_RUN;
            ss_restart <= 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign skip_off     = (state != ST_RUN);
  assign ss_discharge = (state == ST_SKIP);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    skip_done |=> !skip_done);
  assert_entry_discharges_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(skip_off) |-> ss_discharge);
  assert_trip_enters_skip_R4: assert property (@(posedge clk) disable iff (rst)
    hi_s |=> skip_off);
  assert_restart_after_off_R7: assert property (@(posedge clk) disable iff (rst)
    ss_restart |-> ($past(skip_off) && !skip_off));
  assert_done_leaves_timer_R7: assert property (@(posedge clk) disable iff (rst)
    skip_done |-> (skip_off && !ss_discharge));
endmodule

// File: rtl/ocp_out_latch.sv
module ocp_out_latch (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic pwm_on,
  input  logic cyc_term,
  input  logic hi_s,
  input  logic skip_off,
  output logic gate_q
);
  logic clr;

  assign clr = cyc_term | hi_s | skip_off | ~pwm_on;

  always_ff @(posedge clk) begin
    if (rst)                      gate_q <= 1'b0;
    else if (clr)                 gate_q <= 1'b0;
    else if (cyc_start && pwm_on) gate_q <= 1'b1;
  end

  assert_term_wins_R3: assert property (@(posedge clk) disable iff (rst)
    cyc_term |=> !gate_q);
  assert_pwm_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !pwm_on |=> !gate_q);
  assert_set_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(cyc_start));
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard #(
  parameter int SKIP_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_trip_raw,
  input  logic              hi_trip_raw,
  input  logic              cyc_start,
  input  logic              pwm_on,
  input  logic              supply_ok,
  input  logic [SKIP_W-1:0] skip_len,
  output logic              gate_out,
  output logic              cyc_term,
  output logic              skip_off,
  output logic              ss_discharge,
  output logic              skip_done,
  output logic              ss_restart
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flags_s;
  logic             lo_s;
  logic             hi_s;

  ocp_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hi_trip_raw, lo_trip_raw}),
    .q   (flags_s)
  );

  assign lo_s     = flags_s[0];
  assign hi_s     = flags_s[1];
  assign cyc_term = lo_s;

  ocp_skip_timer #(.SKIP_W(SKIP_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .hi_s         (hi_s),
    .supply_ok    (supply_ok),
    .skip_len     (skip_len),
    .skip_off     (skip_off),
    .ss_discharge (ss_discharge),
    .skip_done    (skip_done),
    .ss_restart   (ss_restart)
  );

  ocp_out_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .pwm_on    (pwm_on),
    .cyc_term  (cyc_term),
    .hi_s      (hi_s),
    .skip_off  (skip_off),
    .gate_q    (gate_out)
  );

  assert_skip_blocks_gate_R10: assert property (@(posedge clk) disable iff (rst)
    skip_off |-> !gate_out);
  assert_term_then_low_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_term |=> !gate_out);
endmodule

// File: tb/test_ocp_guard.sv
module test_ocp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SKIP_W     = 12;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst;
  logic              lo_trip_raw, hi_trip_raw, cyc_start, pwm_on, supply_ok;
  logic [SKIP_W-1:0] skip_len;
  logic              gate_out, cyc_term, skip_off, ss_discharge, skip_done, ss_restart;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_guard #(.SKIP_W(SKIP_W), .SYNC_STAGES(2)) i_ocp_guard (
    .clk(clk), .rst(rst), .lo_trip_raw(lo_trip_raw), .hi_trip_raw(hi_trip_raw),
    .cyc_start(cyc_start), .pwm_on(pwm_on), .supply_ok(supply_ok),
    .skip_len(skip_len), .gate_out(gate_out), .cyc_term(cyc_term),
    .skip_off(skip_off), .ss_discharge(ss_discharge), .skip_done(skip_done),
    .ss_restart(ss_restart)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start_cycle();
    cyc_start = 1'b1;
    tick(1);
    cyc_start = 1'b0;
  endtask

  task automatic pulse_hi();
    hi_trip_raw = 1'b1;
    tick(1);
    hi_trip_raw = 1'b0;
  endtask

  // Counts edges from now until skip_done is seen high
  task automatic edges_to_done(output int n);
    n = 0;
    do begin
      tick(1);
      n++;
    end while (!skip_done && n < 500);
  endtask

  task automatic t_reset();
    rst = 1'b1; lo_trip_raw = 0; hi_trip_raw = 0; cyc_start = 0;
    pwm_on = 0; supply_ok = 1; skip_len = 12'd5;
    tick(3);
    check("R1", "outputs in reset",
          {gate_out, cyc_term, skip_off, ss_discharge, skip_done, ss_restart}, 0);
    rst = 1'b0;
    tick(1);
    check("R1", "outputs after reset",
          {gate_out, cyc_term, skip_off, ss_discharge, skip_done, ss_restart}, 0);
  endtask

  task automatic t_normal_pwm();
    pwm_on = 1'b1;
    start_cycle();
    check("R9", "gate after cycle start", gate_out, 1);
    pwm_on = 1'b0;
    tick(1);
    check("R9", "gate after pwm_on drop", gate_out, 0);
    pwm_on = 1'b1;
  endtask

  task automatic t_cycle_limit();
    start_cycle();
    lo_trip_raw = 1'b1;
    tick(1);
    check("R2", "term after one edge", cyc_term, 0);
    tick(1);
    check("R2", "term after two edges", cyc_term, 1);
    check("R2", "gate still high", gate_out, 1);
    tick(1);
    check("R2", "gate after three edges", gate_out, 0);
    check("R2", "no skip on moderate trip", skip_off, 0);
    // reset dominance: start while terminate active
    start_cycle();
    check("R3", "gate with start under terminate", gate_out, 0);
    lo_trip_raw = 1'b0;
    tick(2);
    check("R2", "term cleared", cyc_term, 0);
    start_cycle();
    check("R2", "next cycle starts", gate_out, 1);
  endtask

  task automatic t_skip_basic(input int len);
    int n;
    skip_len = len[SKIP_W-1:0];
    supply_ok = 1'b1;
    start_cycle();
    pulse_hi();
    tick(1);
    check("R4", "skip before third edge", skip_off, 0);
    tick(1);
    check("R4", "skip_off on entry", skip_off, 1);
    check("R4", "discharge on entry", ss_discharge, 1);
    check("R4", "gate off on entry", gate_out, 0);
    start_cycle();
    check("R10", "start ignored in skip", gate_out, 0);
    edges_to_done(n);
    check("R5", "edges to skip_done", n + 3, len + 2);
    tick(1);
    check("R5", "skip_done one clock", skip_done, 0);
    check("R7", "restart pulse", ss_restart, 1);
    check("R7", "skip released", skip_off, 0);
    tick(1);
    check("R7", "restart one clock", ss_restart, 0);
  endtask

  task automatic t_retrigger(input int len);
    int n;
    skip_len = len[SKIP_W-1:0];
    pulse_hi();
    tick(4);
    pulse_hi();
    edges_to_done(n);
    check("R6", "edges to done after retrigger", n, len + 2);
    tick(2);
  endtask

  task automatic t_wait_supply(input int len);
    int n;
    skip_len = len[SKIP_W-1:0];
    supply_ok = 1'b0;
    pulse_hi();
    edges_to_done(n);
    check("R5", "edges to done", n, len + 2);
    tick(5);
    check("R7", "held off without supply", skip_off, 1);
    check("R7", "no discharge while waiting", ss_discharge, 0);
    check("R7", "no restart while waiting", ss_restart, 0);
    start_cycle();
    check("R10", "start ignored while waiting", gate_out, 0);
    supply_ok = 1'b1;
    tick(1);
    check("R7", "released after supply", skip_off, 0);
    check("R7", "restart after supply", ss_restart, 1);
    tick(1);
    check("R7", "restart ends", ss_restart, 0);
    start_cycle();
    check("R9", "gate resumes", gate_out, 1);
  endtask

  task automatic t_zero_len();
    int n;
    skip_len = '0;
    pulse_hi();
    edges_to_done(n);
    check("R8", "zero period acts as one", n, 3);
    tick(2);
  endtask

  initial begin
    t_reset();
    t_normal_pwm();
    t_cycle_limit();
    t_skip_basic(5);
    t_skip_basic(9);
    t_retrigger(9);
    t_wait_supply(6);
    t_zero_len();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule